// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler that has already removed stuff bits. For each frame bit the sampler presents the bit value together with its position in the frame, counted from the start-of-frame bit as index 0. The parser works out which field each position belongs to. It collects the identifier, the frame-type flags, the length code, the data bytes, the CRC field and the acknowledge slot, and checks that the fixed-form bits at the end of the frame are recessive.

Field positions are not fixed. The identifier-extension bit chooses between the short (11-bit identifier) layout and the long (29-bit identifier) layout. After that, the length code moves every later field, including the CRC, the acknowledge slot and the end-of-frame bits. The parser therefore works out the layout as it goes, from the bits it has already captured.

Two signals go back to the sampler. One marks the bit positions where destuffing must run. The other marks the final bit of the frame. A one-cycle pulse then presents the complete decoded frame to the consumer.

Top module: `can_field_parser`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `frame_valid` is low and every decoded output is zero.
- R2: Bits 1 to 11 form the base identifier, most significant bit first. In a frame whose bit 13 is 0 (dominant, short layout), `frame_id` equals the base identifier zero-extended to 29 bits and `frame_ide` is 0.
- R3: In a frame whose bit 13 is 1 (long layout), bits 14 to 31 form an 18-bit extension, MSB first. `frame_id` is (base << 18) | extension and `frame_ide` is 1. `frame_rtr` is taken from bit 32, and the value of bit 12 has no effect on it.
- R4: In the short layout, bit 12 gives `frame_rtr` (1 = remote). In a remote frame of either layout the data field is absent, so the CRC starts right after the length code and `frame_data` is zero.
- R5: The 4-bit length code sits at bits 15..18 (short layout) or bits 35..38 (long layout), MSB first. It is reported in `frame_dlc`. Data byte k, sent MSB first, appears at `frame_data[8k+7:8k]`. Bytes not sent read as zero.
- R6: A length code above 8 carries exactly 8 data bytes. `frame_dlc` still reports the received code.
- R7: The 15 bits after the last data bit form `frame_crc`, MSB first.
- R8: The slot two positions after the last CRC bit is the acknowledge slot. `frame_ack` is 1 when that slot is 0 (dominant).
- R9: `delim_err` is 1 when any of these bits is 0: the CRC delimiter, the acknowledge delimiter, or any of the seven end-of-frame bits. Otherwise it is 0.
- R10: `sof_warn` is 1 when bit 0 is 1 (recessive). Otherwise it is 0.
- R11: `frame_done` is high, combinationally, while the last end-of-frame bit (last data bit + 25) is presented with `bit_valid`. `frame_valid` pulses for exactly one cycle after that bit is taken. The decoded outputs hold their values until the next pulse.
- R12: `stuff_enable` is high while `bit_idx` is at or below the last CRC bit position. It is low for the delimiters, the acknowledge slot and the end-of-frame bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | A destuffed frame bit is presented this cycle |
| bit_val | input | 1 | Bit value, 0 = dominant, 1 = recessive |
| bit_idx | input | 7 | Position of the bit in the frame, 0 = start of frame |
| stuff_enable | output | 1 | Destuffing applies at the presented position |
| frame_done | output | 1 | The presented bit is the last bit of the frame |
| frame_valid | output | 1 | One-cycle pulse: decoded outputs are updated |
| frame_id | output | 29 | Identifier |
| frame_ide | output | 1 | Long layout received |
| frame_rtr | output | 1 | Remote frame |
| frame_dlc | output | 4 | Received length code |
| frame_data | output | 64 | Data bytes, byte 0 in bits 7:0 |
| frame_crc | output | 15 | Received CRC field |
| frame_ack | output | 1 | Acknowledge slot was dominant |
| delim_err | output | 1 | A delimiter or end-of-frame bit was dominant |
| sof_warn | output | 1 | Start-of-frame bit was recessive |

## Verification
The main function is driven with complete frames built in the bench from field values:
- short and long layouts, which shows whether the extension and the moved RTR position are used;
- length codes of 0, 2, 3, 8 and 12, which moves the CRC, acknowledge and end positions by whole bytes;
- remote frames that carry a nonzero length code, which shows whether the data field is correctly left out;
- frames with the acknowledge slot both dominant and recessive.

Directed frames then force each kind of tail bit dominant one at a time, send a recessive start bit, and reset in the middle of a frame. The destuffing window and the done strobe are compared at every position of every frame.

// File: rtl/can_parse_pkg.sv
// Package: shared constants, field roles and the frame record for the
// CAN frame field parser. Positions count destuffed bits from start of frame.
package can_parse_pkg;
    localparam int BASE_W      = 11;
    localparam int EXT_W       = 18;
    localparam int ID_W        = BASE_W + EXT_W;
    localparam int DLC_W       = 4;
    localparam int MAX_BYTES   = 8;
    localparam int DATA_W      = 8 * MAX_BYTES;
    localparam int CRC_W       = 15;
    localparam int EOF_LEN     = 7;
    localparam int IDX_W       = 7;
    localparam int OFF_W       = $clog2(DATA_W);
    localparam int RTR_S_POS   = 12;
    localparam int IDE_POS     = 13;
    localparam int EXT_LO      = 14;
    localparam int EXT_HI      = EXT_LO + EXT_W - 1;
    localparam int RTR_X_POS   = EXT_HI + 1;
    localparam int DLC_END_S   = 18;
    localparam int DLC_END_X   = 38;

    typedef enum logic [3:0] {
        FLD_SOF, FLD_BASE, FLD_RTR_S, FLD_IDE, FLD_EXT, FLD_RTR_X, FLD_RSV,
        FLD_DLC, FLD_DATA, FLD_CRC, FLD_ACK, FLD_FIXED, FLD_LAST, FLD_NONE
    } field_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
        logic              ide;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  crc;
        logic              ack;
        logic              derr;
        logic              sofw;
    } frame_t;
endpackage

// File: rtl/can_field_locator.sv
// Module: maps a bit position to its field role, using the layout flags and
// length code captured so far. Assumes positions up to the length-code end
// do not depend on the length code, which holds for both layouts.
module can_field_locator
    import can_parse_pkg::*;
(
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             ide,
    input  logic             rtr,
    input  logic [DLC_W-1:0] dlc,
    output field_e           field,
    output logic [OFF_W-1:0] data_off,
    output logic             in_stuffed
);
    localparam int CW = IDX_W + 1;

    logic [CW-1:0] idx, dlc_end, last_data, crc_last, frame_end;
    logic [DLC_W-1:0] nbytes;
    logic [OFF_W-1:0] data_start;

    // Purpose: derive the layout-dependent boundaries of the tail fields.
    always_comb begin
        idx        = CW'(bit_idx);
        dlc_end    = ide ? CW'(DLC_END_X) : CW'(DLC_END_S);
        nbytes     = rtr ? '0 : ((dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc);
        last_data  = dlc_end + {1'b0, nbytes, 3'b000};
        crc_last   = last_data + CW'(CRC_W);
        frame_end  = crc_last + CW'(3 + EOF_LEN);
        data_start = ide ? OFF_W'(DLC_END_X + 1) : OFF_W'(DLC_END_S + 1);
        data_off   = bit_idx[OFF_W-1:0] - data_start;
        in_stuffed = (idx <= crc_last);
    end

    // Purpose: pick the field role of the presented position.
    always_comb begin
        field = FLD_NONE;
        if (idx == '0)                         field = FLD_SOF;
        else if (idx < CW'(RTR_S_POS))         field = FLD_BASE;
        else if (idx == CW'(RTR_S_POS))        field = FLD_RTR_S;
        else if (idx == CW'(IDE_POS))          field = FLD_IDE;
        else if (idx <= dlc_end) begin
            if (!ide)
                field = (idx == CW'(EXT_LO)) ? FLD_RSV : FLD_DLC;
            else if (idx <= CW'(EXT_HI))       field = FLD_EXT;
            else if (idx == CW'(RTR_X_POS))    field = FLD_RTR_X;
            else if (idx <= CW'(RTR_X_POS + 2)) field = FLD_RSV;
            else                               field = FLD_DLC;
        end
        else if (idx <= last_data)             field = FLD_DATA;
        else if (idx <= crc_last)              field = FLD_CRC;
        else if (idx == crc_last + CW'(2))     field = FLD_ACK;
        else if (idx < frame_end)              field = FLD_FIXED;
        else if (idx == frame_end)             field = FLD_LAST;
    end
endmodule

// File: rtl/can_field_capture.sv
// Module: working record of the frame being received. Each accepted bit
// updates the field named by its role. The next-state record is exported so
// that the top can latch a frame that includes its final bit.
module can_field_capture
    import can_parse_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_val,
    input  field_e           field,
    input  logic [OFF_W-1:0] data_off,
    output frame_t           nxt,
    output logic             cur_ide,
    output logic             cur_rtr,
    output logic [DLC_W-1:0] cur_dlc
);
    frame_t cur;

    // Purpose: compute the record after the presented bit is applied.
    always_comb begin
        nxt = cur;
        if (bit_valid) begin
            unique case (field)
                FLD_SOF: begin
                    nxt      = '0;
                    nxt.sofw = bit_val;
                end
                FLD_BASE:  nxt.base = {cur.base[BASE_W-2:0], bit_val};
                FLD_RTR_S: nxt.rtr  = bit_val;
                FLD_IDE:   nxt.ide  = bit_val;
                FLD_EXT:   nxt.ext  = {cur.ext[EXT_W-2:0], bit_val};
                FLD_RTR_X: nxt.rtr  = bit_val;
                FLD_DLC:   nxt.dlc  = {cur.dlc[DLC_W-2:0], bit_val};
                FLD_DATA:  nxt.data[{data_off[OFF_W-1:3], ~data_off[2:0]}] = bit_val;
                FLD_CRC:   nxt.crc  = {cur.crc[CRC_W-2:0], bit_val};
                FLD_ACK:   nxt.ack  = ~bit_val;
                FLD_FIXED, FLD_LAST: if (!bit_val) nxt.derr = 1'b1;
                default: ;
            endcase
        end
    end

    // Purpose: hold the working record between bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign cur_ide = cur.ide;
    assign cur_rtr = cur.rtr;
    assign cur_dlc = cur.dlc;
endmodule

// File: rtl/can_field_parser.sv
// Module: top of the CAN frame field parser. Takes destuffed bits with their
// frame positions (assumed in order, starting at 0 for each frame), reports
// the destuffing window and the final bit to the sampler, and publishes the
// decoded frame with a one-cycle pulse.
module can_field_parser
    import can_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              stuff_enable,
    output logic              frame_done,
    output logic              frame_valid,
    output logic [ID_W-1:0]   frame_id,
    output logic              frame_ide,
    output logic              frame_rtr,
    output logic [DLC_W-1:0]  frame_dlc,
    output logic [DATA_W-1:0] frame_data,
    output logic [CRC_W-1:0]  frame_crc,
    output logic              frame_ack,
    output logic              delim_err,
    output logic              sof_warn
);
    field_e           field;
    logic [OFF_W-1:0] data_off;
    frame_t           nxt;
    logic             cur_ide, cur_rtr;
    logic [DLC_W-1:0] cur_dlc;

    can_field_locator u_loc (
        .bit_idx    (bit_idx),
        .ide        (cur_ide),
        .rtr        (cur_rtr),
        .dlc        (cur_dlc),
        .field      (field),
        .data_off   (data_off),
        .in_stuffed (stuff_enable)
    );

    can_field_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .field     (field),
        .data_off  (data_off),
        .nxt       (nxt),
        .cur_ide   (cur_ide),
        .cur_rtr   (cur_rtr),
        .cur_dlc   (cur_dlc)
    );

    assign frame_done = bit_valid && (field == FLD_LAST);

    // Purpose: publish the finished frame and raise the one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            frame_id    <= '0;
            frame_ide   <= 1'b0;
            frame_rtr   <= 1'b0;
            frame_dlc   <= '0;
            frame_data  <= '0;
            frame_crc   <= '0;
            frame_ack   <= 1'b0;
            delim_err   <= 1'b0;
            sof_warn    <= 1'b0;
        end else begin
            frame_valid <= frame_done;
            if (frame_done) begin
                frame_id   <= nxt.ide ? {nxt.base, nxt.ext} : ID_W'(nxt.base);
                frame_ide  <= nxt.ide;
                frame_rtr  <= nxt.rtr;
                frame_dlc  <= nxt.dlc;
                frame_data <= nxt.data;
                frame_crc  <= nxt.crc;
                frame_ack  <= nxt.ack;
                delim_err  <= nxt.derr;
                sof_warn   <= nxt.sofw;
            end
        end
    end
endmodule

// File: rtl/can_field_parser_chk.sv
// Module: protocol checker for the CAN frame field parser, attached by bind.
module can_field_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bit_valid,
    input logic [6:0]  bit_idx,
    input logic        stuff_enable,
    input logic        frame_done,
    input logic        frame_valid,
    input logic [28:0] frame_id,
    input logic        frame_ide,
    input logic        frame_rtr,
    input logic [63:0] frame_data
);
    // R11: the completion pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R11: every pulse follows a final-bit strobe
    a_r11_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(frame_done));
    // R12: start of frame is inside the destuffing window
    a_r12_sof_stuffed: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_idx == 7'd0) |-> stuff_enable);
    // R12: the final bit is outside the destuffing window
    a_r12_tail_unstuffed: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !stuff_enable);
    // R4: remote frames publish no data
    a_r4_remote_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_rtr) |-> (frame_data == 64'd0));
    // R2: short-layout identifiers fit in 11 bits
    a_r2_short_id: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_ide) |-> (frame_id[28:11] == 18'd0));
endmodule

bind can_field_parser can_field_parser_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_valid    (bit_valid),
    .bit_idx      (bit_idx),
    .stuff_enable (stuff_enable),
    .frame_done   (frame_done),
    .frame_valid  (frame_valid),
    .frame_id     (frame_id),
    .frame_ide    (frame_ide),
    .frame_rtr    (frame_rtr),
    .frame_data   (frame_data)
);

// File: tb/can_field_parser_tb.sv
// Bench: builds whole frames from field values, feeds them bit by bit and
// compares every output against values derived from the requirements.
module can_field_parser_tb;
    typedef struct packed {
        logic [10:0] base;
        logic [17:0] ext;
        logic        ide;
        logic        srr;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic [14:0] crc;
        logic        ack_bit;
    } row_t;

    localparam int NROWS = 7;
    localparam row_t TABLE [NROWS] = '{
        '{11'h123, 18'h0,     1'b0, 1'b0, 1'b0, 4'd2, 64'h0000_0000_0000_BBAA, 15'h1A2B, 1'b0},
        '{11'h7F0, 18'h0,     1'b0, 1'b0, 1'b0, 4'd0, 64'h0,                   15'h7FFF, 1'b1},
        '{11'h001, 18'h0,     1'b0, 1'b0, 1'b0, 4'd8, 64'h8877_6655_4433_2211, 15'h0001, 1'b0},
        '{11'h5A5, 18'h2C3D1, 1'b1, 1'b1, 1'b0, 4'd3, 64'h0000_0000_00C0_FFEE, 15'h4321, 1'b0},
        '{11'h3FF, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 4'd4, 64'h0000_0000_DEAD_BEEF, 15'h2AAA, 1'b0},
        '{11'h400, 18'h0,     1'b0, 1'b0, 1'b1, 4'd5, 64'h0000_0012_3456_789A, 15'h5555, 1'b0},
        '{11'h000, 18'h00001, 1'b1, 1'b1, 1'b0, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h3CC3, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_val = 1'b1;
    logic [6:0]  bit_idx = '0;
    logic        stuff_enable, frame_done, frame_valid;
    logic [28:0] frame_id;
    logic        frame_ide, frame_rtr, frame_ack, delim_err, sof_warn;
    logic [3:0]  frame_dlc;
    logic [63:0] frame_data;
    logic [14:0] frame_crc;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    can_field_parser u_dut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    // Send one frame; corrupt_off > 0 forces bit (last data + corrupt_off) dominant.
    task automatic run_frame(input row_t r, input logic sof_bit, input int corrupt_off,
                             input logic exp_derr, input string tag);
        logic b [0:127];
        int p, neff, last_data, crc_last, n, se_bad, fd_bad;
        logic [63:0] exp_data, exp_id;
        p = 0;
        b[p++] = sof_bit;
        for (int i = 10; i >= 0; i--) b[p++] = r.base[i];
        b[p++] = r.ide ? r.srr : r.rtr;
        b[p++] = r.ide;
        if (!r.ide) begin
            b[p++] = 1'b0;
        end else begin
            for (int i = 17; i >= 0; i--) b[p++] = r.ext[i];
            b[p++] = r.rtr;
            b[p++] = 1'b0;
            b[p++] = 1'b0;
        end
        for (int i = 3; i >= 0; i--) b[p++] = r.dlc[i];
        neff = r.rtr ? 0 : ((r.dlc > 8) ? 8 : int'(r.dlc));
        for (int k = 0; k < neff; k++)
            for (int j = 7; j >= 0; j--) b[p++] = r.data[8*k + j];
        last_data = p - 1;
        for (int i = 14; i >= 0; i--) b[p++] = r.crc[i];
        crc_last = p - 1;
        b[p++] = 1'b1;
        b[p++] = r.ack_bit;
        b[p++] = 1'b1;
        for (int i = 0; i < 7; i++) b[p++] = 1'b1;
        n = p;
        if (corrupt_off > 0) b[last_data + corrupt_off] = 1'b0;
        exp_data = (neff == 8) ? r.data : (r.data & ((64'd1 << (8*neff)) - 64'd1));
        exp_id = r.ide ? {35'd0, r.base, r.ext} : {53'd0, r.base};
        se_bad = 0;
        fd_bad = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bit_valid = 1'b1;
            bit_idx   = 7'(i);
            bit_val   = b[i];
            #1;
            if (stuff_enable !== (i <= crc_last)) se_bad++;
            if (frame_done !== (i == n - 1)) fd_bad++;
            @(negedge clk);
        end
        bit_valid = 1'b0;
        check({tag, " R12 stuff window mismatches"}, 64'(se_bad), 64'd0);
        check({tag, " R11 frame_done mismatches"}, 64'(fd_bad), 64'd0);
        check({tag, " R11 frame_valid pulse"}, 64'(frame_valid), 64'd1);
        check({tag, " R2/R3 id"}, 64'(frame_id), exp_id);
        check({tag, " R2/R3 ide"}, 64'(frame_ide), 64'(r.ide));
        check({tag, " R3/R4 rtr"}, 64'(frame_rtr), 64'(r.rtr));
        check({tag, " R5/R6 dlc"}, 64'(frame_dlc), 64'(r.dlc));
        check({tag, " R5/R6 data"}, frame_data, exp_data);
        check({tag, " R7 crc"}, 64'(frame_crc), 64'(r.crc));
        check({tag, " R8 ack"}, 64'(frame_ack), 64'(!r.ack_bit));
        check({tag, " R9 delim_err"}, 64'(delim_err), 64'(exp_derr));
        check({tag, " R10 sof_warn"}, 64'(sof_warn), 64'(sof_bit));
        @(negedge clk);
        check({tag, " R11 pulse ends"}, 64'(frame_valid), 64'd0);
        check({tag, " R11 outputs held"}, frame_data, exp_data);
    endtask

    task automatic check_cleared(input string tag);
        check({tag, " R1 frame_valid"}, 64'(frame_valid), 64'd0);
        check({tag, " R1 id"}, 64'(frame_id), 64'd0);
        check({tag, " R1 data"}, frame_data, 64'd0);
        check({tag, " R1 flags"}, 64'({frame_ide, frame_rtr, frame_dlc, frame_crc,
                                        frame_ack, delim_err, sof_warn}), 64'd0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        row_t r;
        repeat (3) @(negedge clk);
        check_cleared("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_cleared("post-reset");

        for (int i = 0; i < NROWS; i++)
            run_frame(TABLE[i], 1'b0, 0, 1'b0, $sformatf("row%0d", i));

        // R6: length code 12 carries eight bytes
        r = TABLE[2];
        r.dlc = 4'd12;
        run_frame(r, 1'b0, 0, 1'b0, "dlc12 R6");

        // R10: recessive start bit
        run_frame(TABLE[0], 1'b1, 0, 1'b0, "sof R10");

        // R9: each kind of tail bit forced dominant
        run_frame(TABLE[0], 1'b0, 16, 1'b1, "crc-delim R9");
        run_frame(TABLE[3], 1'b0, 18, 1'b1, "ack-delim R9");
        run_frame(TABLE[6], 1'b0, 25, 1'b1, "eof-last R9");

        // R1: reset in the middle of a frame clears the published outputs
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            bit_valid = 1'b1;
            bit_idx   = 7'(i);
            bit_val   = (i == 0) ? 1'b0 : i[0];
            @(negedge clk);
        end
        bit_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_cleared("mid-frame reset");
        @(negedge clk);
        check_cleared("after mid-frame reset");
        run_frame(TABLE[3], 1'b0, 0, 1'b0, "recovery");

        summary();
        $finish;
    end
endmodule